// File: doc/BRIEF.md
# Receive Frame Word Reader with Alignment Padding

This block is the host-facing read side of a receive data store. A producer pushes 32-bit words into a circular buffer and, once a frame's words are stored, pushes that frame's word count into a small length queue. The host pulls one word per read strobe. Each frame can be returned with a programmable run of leading zero words in front of it. It can also be followed by trailing zero words, so that the host sees a fixed burst granularity.

A skip command throws away whatever remains of the current frame, or the whole next frame when none is open. A dump command empties everything. A read with nothing pending returns zero and raises a sticky error flag. A fill-level word reports the stored data in bytes and the number of frame status entries that are outstanding. The buffer depth need not be a power of two, and the pointers wrap modulo the depth.

Top module: `rx_frame_reader`

## Requirements
- R1: After reset, `rd_data_o` is 0, `level_o` is 0 and `rx_err_o` is 0.
- R2: A read while no frame is open (remaining words and remaining pad both zero) and the length queue is not empty opens the next frame. The leading zero word count is taken from `cfg_offset_i` at that read and is not affected by later changes to `cfg_offset_i`.
- R3: A frame is returned as: leading zero words, then the stored words in push order, then trailing zero pad words. Each read updates `rd_data_o` at the next rising clock edge.
- R4: `cfg_align_i` sampled at frame open selects the trailing pad. 1 pads offset plus length up to a multiple of 4 words, 2 pads it up to a multiple of 8 words, and 0 or 3 adds no pad.
- R5: A read with no open frame and an empty length queue returns 0 and sets `rx_err_o`. `rx_err_o` stays set until `err_clr_i` is asserted in a cycle with no new error.
- R6: A read with no open frame and an empty length queue leaves `level_o` unchanged.
- R7: `skip_i` during an open frame drops the frame's remaining data words, leading zeros and pad. The next read opens the following frame.
- R8: `skip_i` with no open frame drops the whole next queued frame. If the queue is empty, it sets `rx_err_o` and changes nothing else.
- R9: `dump_i` empties the data buffer, the length queue and the status count, so `level_o` reads 0 afterwards. A later read then underflows as in R5.
- R10: `level_o[15:0]` is the stored word count times 4, and `level_o[31:16]` is the status count. An accepted frame-length push increments the status count, and `stat_pop_i` decrements it (not below 0).
- R11: The buffer read and write positions wrap modulo `DATA_DEPTH`, and data stays intact across the wrap.
- R12: A word pushed while the buffer holds `DATA_DEPTH` words is dropped, so `level_o[15:0]` never exceeds `DATA_DEPTH*4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_offset_i | input | 3 | Leading zero words per frame |
| cfg_align_i | input | 2 | End alignment select |
| push_word_i | input | 1 | Push a data word |
| push_data_i | input | 32 | Data word to push |
| push_frame_i | input | 1 | Push a frame length |
| push_len_i | input | CW | Frame length in words (0 ignored) |
| rd_i | input | 1 | Read strobe |
| skip_i | input | 1 | Skip rest of frame (wins over rd_i) |
| dump_i | input | 1 | Empty all storage (wins over all) |
| err_clr_i | input | 1 | Clear the underflow flag |
| stat_pop_i | input | 1 | Retire one status entry |
| rd_data_o | output | 32 | Word returned by last read |
| level_o | output | 32 | {status count, stored bytes} |
| rx_err_o | output | 1 | Sticky underflow flag |

## Verification
The bench sweeps the offset across every alignment mode, so a wrong pad formula shows up as missing or extra zero words at the end of a frame. It changes the offset in the middle of a frame, which catches a design that reads the offset live instead of latching it when the frame opens. It covers a skip in the middle of a frame and a skip with no frame open. A wrong head advance in either case returns words from the wrong frame. It also drives the pointers across the non-power-of-two wrap and fills the buffer to overflow, where a binary wrap or an unguarded count would corrupt data or report a level above the depth.

// File: rtl/rx_frame_reader_pkg.sv
package rx_frame_reader_pkg;
  typedef enum logic [1:0] {
    ALIGN_NONE = 2'd0,
    ALIGN_4    = 2'd1,
    ALIGN_8    = 2'd2,
    ALIGN_RSVD = 2'd3
  } align_e;

  // zero words needed so that off + len lands on the chosen boundary
  function automatic logic [2:0] pad_words(input logic [2:0] off,
                                           input logic [2:0] len_lsb,
                                           input align_e     mode);
    logic [2:0] neg;
    neg = 3'(~(off + len_lsb) + 3'd1);
    case (mode)
      ALIGN_4: return {1'b0, neg[1:0]};
      ALIGN_8: return neg;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rx_word_store.sv
module rx_word_store #(
  parameter int unsigned DEPTH = 48,
  parameter int unsigned DW    = 32,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          adv_i,
  input  logic [CW-1:0] adv_cnt_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] used_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head_q;
  logic [CW-1:0] used_q;
  logic          wr_ok;
  logic [CW-1:0] adv_eff;
  logic [PW-1:0] wptr, head_nxt;

  function automatic logic [PW-1:0] wrap(input logic [CW:0] s);
    if (s >= (CW+1)'(DEPTH)) return PW'(s - (CW+1)'(DEPTH));
    return PW'(s);
  endfunction

  assign wr_ok    = wr_i && (used_q < CW'(DEPTH));
  assign adv_eff  = !adv_i ? '0 : ((adv_cnt_i > used_q) ? used_q : adv_cnt_i);
  assign wptr     = wrap((CW+1)'(head_q) + (CW+1)'(used_q));
  assign head_nxt = wrap((CW+1)'(head_q) + (CW+1)'(adv_eff));

  always_ff @(posedge clk_i) begin
    if (wr_ok && !clr_i) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      used_q <= '0;
    end else if (clr_i) begin
      used_q <= '0;
    end else begin
      head_q <= head_nxt;
      used_q <= used_q + CW'(wr_ok) - adv_eff;
    end
  end

  assign rdata_o = mem[head_q];
  assign used_o  = used_q;
endmodule

// File: rtl/rx_len_queue.sv
module rx_len_queue #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW    = 6,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [LW-1:0] len_i,
  input  logic          pop_i,
  output logic [LW-1:0] head_len_o,
  output logic          empty_o,
  output logic          accept_o
);
  logic [LW-1:0] ent [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [AW:0]   cnt_q;
  logic          pop_ok;

  assign empty_o  = (cnt_q == '0);
  assign accept_o = push_i && (len_i != '0) && (cnt_q != (AW+1)'(DEPTH)) && !clr_i;
  assign pop_ok   = pop_i && !empty_o && !clr_i;

  always_ff @(posedge clk_i) begin
    if (accept_o) ent[wr_q] <= len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= rd_q;
      cnt_q <= '0;
    end else begin
      if (accept_o) wr_q <= wr_q + 1'b1;
      if (pop_ok)   rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(accept_o) - (AW+1)'(pop_ok);
    end
  end

  assign head_len_o = ent[rd_q];
endmodule

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
  import rx_frame_reader_pkg::*;
#(
  parameter int unsigned LW = 6,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          skip_i,
  input  logic          dump_i,
  input  logic          err_clr_i,
  input  logic [2:0]    off_cfg_i,
  input  align_e        align_i,
  input  logic          q_empty_i,
  input  logic [LW-1:0] q_len_i,
  input  logic [DW-1:0] word_i,
  output logic          q_pop_o,
  output logic          adv_o,
  output logic [LW-1:0] adv_cnt_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          idle_o
);
  logic [2:0]    off_q, off_d, eoff;
  logic [2:0]    pad_q, pad_d, epad;
  logic [LW-1:0] size_q, size_d, esz;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          err_set, have;

  assign idle_o = (size_q == '0) && (pad_q == '0);
  assign have   = !idle_o || !q_empty_i;
  assign eoff   = idle_o ? off_cfg_i : off_q;
  assign esz    = idle_o ? q_len_i   : size_q;
  assign epad   = idle_o ? pad_words(off_cfg_i, q_len_i[2:0], align_i) : pad_q;

  always_comb begin
    off_d     = off_q;
    size_d    = size_q;
    pad_d     = pad_q;
    rdata_d   = rdata_q;
    q_pop_o   = 1'b0;
    adv_o     = 1'b0;
    adv_cnt_o = '0;
    err_set   = 1'b0;
    if (dump_i) begin
      off_d  = '0;
      size_d = '0;
      pad_d  = '0;
    end else if (skip_i) begin
      if (have) begin
        q_pop_o   = idle_o;
        adv_o     = 1'b1;
        adv_cnt_o = esz;
        off_d     = '0;
        size_d    = '0;
        pad_d     = '0;
      end else begin
        err_set = 1'b1;
      end
    end else if (rd_i) begin
      rdata_d = '0;
      if (!have) begin
        err_set = 1'b1;
      end else begin
        q_pop_o = idle_o;
        size_d  = esz;
        pad_d   = epad;
        if (eoff != '0) begin
          off_d = eoff - 3'd1;
        end else if (esz != '0) begin
          off_d     = '0;
          rdata_d   = word_i;
          adv_o     = 1'b1;
          adv_cnt_o = LW'(1);
          size_d    = esz - LW'(1);
        end else begin
          off_d = '0;
          pad_d = epad - 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= '0;
      size_q  <= '0;
      pad_q   <= '0;
      rdata_q <= '0;
      err_o   <= 1'b0;
    end else begin
      off_q   <= off_d;
      size_q  <= size_d;
      pad_q   <= pad_d;
      rdata_q <= rdata_d;
      if (err_set)        err_o <= 1'b1;
      else if (err_clr_i) err_o <= 1'b0;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rx_frame_reader.sv
module rx_frame_reader
  import rx_frame_reader_pkg::*;
#(
  parameter int unsigned DATA_DEPTH = 48,
  parameter int unsigned LEN_DEPTH  = 8,
  parameter int unsigned STAT_DEPTH = 16,
  localparam int unsigned CW        = $clog2(DATA_DEPTH + 1),
  localparam int unsigned SW        = $clog2(STAT_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cfg_offset_i,
  input  logic [1:0]    cfg_align_i,
  input  logic          push_word_i,
  input  logic [31:0]   push_data_i,
  input  logic          push_frame_i,
  input  logic [CW-1:0] push_len_i,
  input  logic          rd_i,
  input  logic          skip_i,
  input  logic          dump_i,
  input  logic          err_clr_i,
  input  logic          stat_pop_i,
  output logic [31:0]   rd_data_o,
  output logic [31:0]   level_o,
  output logic          rx_err_o
);
  logic [31:0]   word;
  logic [CW-1:0] used, q_len, adv_cnt;
  logic          q_empty, q_accept, q_pop, adv, seq_idle;
  logic [SW-1:0] stat_q;

  rx_word_store #(.DEPTH(DATA_DEPTH), .DW(32)) store_i (
    .clk_i, .rst_ni, .clr_i(dump_i),
    .wr_i(push_word_i), .wdata_i(push_data_i),
    .adv_i(adv), .adv_cnt_i(adv_cnt),
    .rdata_o(word), .used_o(used)
  );

  rx_len_queue #(.DEPTH(LEN_DEPTH), .LW(CW)) lenq_i (
    .clk_i, .rst_ni, .clr_i(dump_i),
    .push_i(push_frame_i), .len_i(push_len_i), .pop_i(q_pop),
    .head_len_o(q_len), .empty_o(q_empty), .accept_o(q_accept)
  );

  rx_frame_seq #(.LW(CW), .DW(32)) seq_i (
    .clk_i, .rst_ni, .rd_i, .skip_i, .dump_i, .err_clr_i,
    .off_cfg_i(cfg_offset_i), .align_i(align_e'(cfg_align_i)),
    .q_empty_i(q_empty), .q_len_i(q_len), .word_i(word),
    .q_pop_o(q_pop), .adv_o(adv), .adv_cnt_o(adv_cnt),
    .rdata_o(rd_data_o), .err_o(rx_err_o), .idle_o(seq_idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else if (dump_i) stat_q <= '0;
    else
      stat_q <= stat_q + SW'(q_accept && (stat_q != SW'(STAT_DEPTH)))
                       - SW'(stat_pop_i && (stat_q != '0));
  end

  assign level_o = {16'(stat_q), 16'({used, 2'b00})};
endmodule

// File: rtl/rx_frame_reader_chk.sv
module rx_frame_reader_chk #(
  parameter int unsigned DATA_DEPTH = 48
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic        skip_i,
  input logic        dump_i,
  input logic        err_clr_i,
  input logic        push_word_i,
  input logic        stat_pop_i,
  input logic [31:0] rd_data_o,
  input logic [31:0] level_o,
  input logic        rx_err_o,
  input logic        seq_idle_i,
  input logic        q_empty_i
);
  logic empty_rd;
  assign empty_rd = rd_i && !skip_i && !dump_i && seq_idle_i && q_empty_i;

  // R12
  level_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o[15:0] <= 16'(DATA_DEPTH * 4));

  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o && !err_clr_i |=> rx_err_o);

  // R5
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_rd |=> rx_err_o && (rd_data_o == 32'd0));

  // R6
  empty_rd_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_rd && !push_word_i && !stat_pop_i |=> $stable(level_o));

  // R9
  dump_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_i |=> level_o == 32'd0);
endmodule

bind rx_frame_reader rx_frame_reader_chk #(.DATA_DEPTH(DATA_DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .skip_i(skip_i),
  .dump_i(dump_i), .err_clr_i(err_clr_i), .push_word_i(push_word_i),
  .stat_pop_i(stat_pop_i), .rd_data_o(rd_data_o), .level_o(level_o),
  .rx_err_o(rx_err_o), .seq_idle_i(seq_idle), .q_empty_i(q_empty)
);

// File: tb/rx_frame_reader_tb_top.sv
module rx_frame_reader_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cfg_offset_i = '0;
  logic [1:0]  cfg_align_i = '0;
  logic        push_word_i = 1'b0;
  logic [31:0] push_data_i = '0;
  logic        push_frame_i = 1'b0;
  logic [5:0]  push_len_i = '0;
  logic        rd_i = 1'b0, skip_i = 1'b0, dump_i = 1'b0;
  logic        err_clr_i = 1'b0, stat_pop_i = 1'b0;
  logic [31:0] rd_data_o, level_o;
  logic        rx_err_o;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk_i = ~clk_i;

  rx_frame_reader dut_i (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s got %h exp %h", t, act, exp);
    end
  endtask

  // monitor: compare each returned word against the scoreboard
  always @(posedge clk_i) rd_seen <= rd_i && !skip_i && !dump_i && rst_ni;
  always @(negedge clk_i) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected read got %h exp none", rd_data_o);
      end else begin
        chk(rd_data_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic rd_exp(input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic push_frame(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      push_word_i = 1'b1; push_data_i = base + 32'(i);
      @(negedge clk_i);
    end
    push_word_i = 1'b0;
    push_frame_i = 1'b1; push_len_i = 6'(n);
    @(negedge clk_i);
    push_frame_i = 1'b0;
  endtask

  task automatic rd_frame(input int off, input int mode, input int n,
                          input logic [31:0] base, input string t);
    int tot, pad;
    tot = off + n;
    pad = (mode == 1) ? (4 - tot % 4) % 4 : (mode == 2) ? (8 - tot % 8) % 8 : 0;
    cfg_offset_i = 3'(off); cfg_align_i = 2'(mode);
    for (int i = 0; i < off; i++) rd_exp(32'd0, {t, " lead"});
    for (int i = 0; i < n; i++)   rd_exp(base + 32'(i), {t, " data"});
    for (int i = 0; i < pad; i++) rd_exp(32'd0, {t, " pad"});
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk_i); s = 1'b0;
  endtask

  initial begin
    #100000000;
    total++; bad++;
    $display("FAIL watchdog got hang exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lv;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(rd_data_o, 32'd0, "R1 rd_data");
    chk(level_o, 32'd0, "R1 level");
    chk(32'(rx_err_o), 32'd0, "R1 err");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 level format, R3 plain frame
    push_frame(5, 32'hA000_0000);
    chk(level_o, {16'd1, 16'd20}, "R10 level after push");
    rd_frame(0, 0, 5, 32'hA000_0000, "R3 frame A");
    chk(level_o, {16'd1, 16'd0}, "R10 level after read");
    pulse(stat_pop_i);
    chk(level_o, 32'd0, "R10 status pop");

    // R2 offset, R4 align 4
    push_frame(5, 32'hB000_0000);
    rd_frame(2, 1, 5, 32'hB000_0000, "R4 align4 off2");
    pulse(stat_pop_i);

    // R5 R6 underflow
    lv = level_o;
    rd_exp(32'd0, "R5 underflow data");
    chk(32'(rx_err_o), 32'd1, "R5 err set");
    chk(level_o, lv, "R6 level unchanged");
    @(negedge clk_i);
    chk(32'(rx_err_o), 32'd1, "R5 err sticky");
    pulse(err_clr_i);
    chk(32'(rx_err_o), 32'd0, "R5 err cleared");

    // R2 offset sampled at frame open, R4 align 8
    push_frame(6, 32'hC000_0000);
    cfg_offset_i = 3'd3; cfg_align_i = 2'd2;
    rd_exp(32'd0, "R2 lead 0");
    cfg_offset_i = 3'd0;
    rd_exp(32'd0, "R2 lead 1");
    rd_exp(32'd0, "R2 lead 2");
    for (int i = 0; i < 6; i++) rd_exp(32'hC000_0000 + 32'(i), "R2 data");
    for (int i = 0; i < 7; i++) rd_exp(32'd0, "R4 align8 pad");
    pulse(stat_pop_i);

    // R4 mode 3 adds no pad
    push_frame(3, 32'hD000_0000);
    rd_frame(1, 3, 3, 32'hD000_0000, "R4 mode3");
    pulse(stat_pop_i);
    rd_exp(32'd0, "R4 no pad after mode3");
    pulse(err_clr_i);

    // R7 skip in open frame
    push_frame(6, 32'hE000_0000);
    push_frame(3, 32'hE100_0000);
    cfg_offset_i = 3'd0; cfg_align_i = 2'd0;
    rd_exp(32'hE000_0000, "R7 B0");
    rd_exp(32'hE000_0001, "R7 B1");
    chk(32'(level_o[15:0]), 32'd28, "R7 level before skip");
    pulse(skip_i);
    chk(32'(level_o[15:0]), 32'd12, "R7 level after skip");
    rd_frame(0, 0, 3, 32'hE100_0000, "R7 next frame");

    // R8 skip with no open frame
    push_frame(4, 32'hF000_0000);
    push_frame(2, 32'hF100_0000);
    chk(32'(level_o[15:0]), 32'd24, "R8 level before skip");
    pulse(skip_i);
    chk(32'(level_o[15:0]), 32'd8, "R8 level after skip");
    chk(32'(rx_err_o), 32'd0, "R8 no err");
    rd_frame(0, 0, 2, 32'hF100_0000, "R8 following frame");
    pulse(skip_i);
    chk(32'(rx_err_o), 32'd1, "R8 skip empty err");
    chk(32'(level_o[15:0]), 32'd0, "R8 skip empty level");
    pulse(err_clr_i);

    // R11 wrap past non-power-of-two depth
    for (int k = 0; k < 3; k++) begin
      push_frame(20, 32'h1000_0000 * (k + 1));
      chk(32'(level_o[15:0]), 32'd80, "R11 level");
      rd_frame(1, 1, 20, 32'h1000_0000 * (k + 1), "R11 wrap frame");
    end

    // R12 overflow, R9 dump
    pulse(dump_i);
    for (int i = 0; i < 50; i++) begin
      push_word_i = 1'b1; push_data_i = 32'(i);
      @(negedge clk_i);
    end
    push_word_i = 1'b0;
    chk(32'(level_o[15:0]), 32'd192, "R12 level saturates");
    pulse(push_frame_i);
    pulse(dump_i);
    chk(level_o, 32'd0, "R9 level after dump");
    rd_exp(32'd0, "R9 read after dump");
    chk(32'(rx_err_o), 32'd1, "R9 err after dump read");

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R3 pending reads got %0d exp 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule